// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a small bank of binary ownership flags that two independent agents, a left port and a right port, use to pass a token for a shared resource. To request a flag, an agent writes a zero to it. It then reads the flag back to learn whether it won. A flag is active low: the side that holds it reads zero, and the opposite side reads one. Writing a one from the holding side gives the flag up.

Each flag keeps one request latch per side. While the opposite side holds the flag, a request is remembered. When the holder releases, the flag goes straight to the waiting side and is never free in between. Reads return the flag as seen by the reading side, copied onto every data bit. The value is frozen from the cycle a read begins until that read ends, so an agent that polls must end its read and start a new one to see a change. The whole design runs on one clock with a synchronous reset.

Top module: `sem_bank`

## Requirements
- R1: The flag is chosen by the low `$clog2(NUM_FLAGS)` address bits (3 bits for eight flags). Higher address bits have no effect.
- R2: A write takes only data bit 0. Data bits above bit 0 have no effect on any flag.
- R3: A write of 0 to a free flag gives that flag to the writer. After that, the writer reads all zeros and the other side reads all ones.
- R4: A write of 0 by the side that does not hold the flag changes no read value. The request stays pending in that side's latch. A write of 1 by that side only withdraws its own pending request.
- R5: When the holder writes 1 and the other side has a request pending, ownership moves to the waiting side at that clock edge. With no request pending, the flag becomes free.
- R6: A read is sel=1, oe=1, wrEn=0. From the cycle after the first edge of a read, rdata shows the flag on all DATA_W bits: all zeros if the reading side holds the flag, all ones otherwise. The value is the flag state just before that edge.
- R7: While a read stays active, rdata does not change, even if the flag changes. rdata is updated only when a new read starts.
- R8: When both sides write 0 to the same free flag in the same cycle, the left side wins if TIE_LEFT=1 and the right side wins if TIE_LEFT=0. The losing side's request stays pending.
- R9: After reset, every flag is free, every request latch is idle, and both rdata buses read all ones.
- R10: A cycle with sel=0 changes no flag, whatever wrEn and the data are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lSel | input | 1 | Left semaphore select |
| lWrEn | input | 1 | Left write enable (1 = write, 0 = read) |
| lOe | input | 1 | Left output enable |
| lAddr | input | ADDR_W | Left address; the low bits pick the flag |
| lWdata | input | DATA_W | Left write data; only bit 0 is used |
| lRdata | output | DATA_W | Left read value, frozen while a read is active |
| rSel | input | 1 | Right semaphore select |
| rWrEn | input | 1 | Right write enable (1 = write, 0 = read) |
| rOe | input | 1 | Right output enable |
| rAddr | input | ADDR_W | Right address; the low bits pick the flag |
| rWdata | input | DATA_W | Right write data; only bit 0 is used |
| rRdata | output | DATA_W | Right read value, frozen while a read is active |

## Verification
The hardest case to reach is a handoff that happens while the waiting side is already in a read. The bench sets this up directly: the right side takes a flag, the left side leaves a pending request, and the left side starts a read and keeps it active. The right side then releases. rdata must keep showing ones until the read ends, and only a fresh read may show the zeros of the new owner. Random two-sided traffic, with frequent same-flag collisions and aliased upper address bits, covers ties and withdrawn requests. Every flag is read back from both sides and compared with a bench model.

// File: rtl/sem_pkg.sv
package sem_pkg;

  // who holds a flag
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  // per-port strobes from control to datapath
  typedef struct packed {
    logic wrStb;   // write to the indexed flag this cycle
    logic wrBit;   // value written (bit 0 of data)
    logic capStb;  // first cycle of a read: capture view
  } portStb_t;

  localparam int SIDES = 2;

endpackage

// File: rtl/sem_ctrl.sv
module sem_ctrl
  import sem_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [SIDES-1:0]              sel,
  input  logic [SIDES-1:0]              wrEn,
  input  logic [SIDES-1:0]              oe,
  input  logic [SIDES-1:0][ADDR_W-1:0]  addr,
  input  logic [SIDES-1:0][DATA_W-1:0]  wdata,
  output portStb_t [SIDES-1:0]          stb,
  output logic [SIDES-1:0][IDX_W-1:0]   idx
);

  logic [SIDES-1:0] readAct;
  logic [SIDES-1:0] prevAct;

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    assign readAct[s]    = sel[s] & oe[s] & ~wrEn[s];
    assign stb[s].wrStb  = sel[s] & wrEn[s];
    assign stb[s].wrBit  = wdata[s][0];
    assign stb[s].capStb = readAct[s] & ~prevAct[s];
    assign idx[s]        = addr[s][IDX_W-1:0];

    // bits outside the flag index and bit 0 carry no meaning here
    logic unusedOk;
    assign unusedOk = ^{addr[s][ADDR_W-1:IDX_W], wdata[s][DATA_W-1:1]};

    always_ff @(posedge clk) begin
      if (rst) prevAct[s] <= 1'b0;
      else     prevAct[s] <= readAct[s];
    end
  end

endmodule

// File: rtl/sem_cell.sv
module sem_cell
  import sem_pkg::*;
#(
  parameter bit TIE_LEFT = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic wrL,
  input  logic bitL,
  input  logic wrR,
  input  logic bitR,
  output logic reqL,
  output logic reqR,
  output logic ownL,
  output logic ownR
);

  logic   reqLQ, reqRQ, nReqL, nReqR;
  owner_e ownerQ, ownerD;

  always_comb begin
    nReqL  = wrL ? bitL : reqLQ;
    nReqR  = wrR ? bitR : reqRQ;
    ownerD = ownerQ;
    unique case (ownerQ)
      OWN_NONE: begin
        if (!nReqL && !nReqR) ownerD = TIE_LEFT ? OWN_LEFT : OWN_RIGHT;
        else if (!nReqL)      ownerD = OWN_LEFT;
        else if (!nReqR)      ownerD = OWN_RIGHT;
        else                  ownerD = OWN_NONE;
      end
      OWN_LEFT:  if (nReqL) ownerD = nReqR ? OWN_NONE : OWN_RIGHT;
      OWN_RIGHT: if (nReqR) ownerD = nReqL ? OWN_NONE : OWN_LEFT;
      default:   ownerD = OWN_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reqLQ  <= 1'b1;
      reqRQ  <= 1'b1;
      ownerQ <= OWN_NONE;
    end else begin
      reqLQ  <= nReqL;
      reqRQ  <= nReqR;
      ownerQ <= ownerD;
    end
  end

  assign reqL = reqLQ;
  assign reqR = reqRQ;
  assign ownL = (ownerQ == OWN_LEFT);
  assign ownR = (ownerQ == OWN_RIGHT);

endmodule

// File: rtl/sem_datapath.sv
module sem_datapath
  import sem_pkg::*;
#(
  parameter int NUM_FLAGS = 8,
  parameter int DATA_W    = 8,
  parameter int IDX_W     = 3,
  parameter bit TIE_LEFT  = 1'b1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  portStb_t [SIDES-1:0]         stb,
  input  logic [SIDES-1:0][IDX_W-1:0]  idx,
  output logic [SIDES-1:0][DATA_W-1:0] rdata,
  output logic [NUM_FLAGS-1:0]         reqL,
  output logic [NUM_FLAGS-1:0]         reqR,
  output logic [NUM_FLAGS-1:0]         ownL,
  output logic [NUM_FLAGS-1:0]         ownR
);

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
    sem_cell #(.TIE_LEFT(TIE_LEFT)) u_cell (
      .clk (clk),
      .rst (rst),
      .wrL (stb[0].wrStb && (idx[0] == IDX_W'(f))),
      .bitL(stb[0].wrBit),
      .wrR (stb[1].wrStb && (idx[1] == IDX_W'(f))),
      .bitR(stb[1].wrBit),
      .reqL(reqL[f]),
      .reqR(reqR[f]),
      .ownL(ownL[f]),
      .ownR(ownR[f])
    );
  end

  // flag as each side sees it: 0 when that side holds it
  logic [SIDES-1:0][NUM_FLAGS-1:0] view;
  assign view[0] = ~ownL;
  assign view[1] = ~ownR;

  for (genvar s = 0; s < SIDES; s++) begin : g_rd
    logic viewBit;
    assign viewBit = (32'(idx[s]) < NUM_FLAGS) ? view[s][idx[s]] : 1'b1;
    always_ff @(posedge clk) begin
      if (rst)                rdata[s] <= '1;
      else if (stb[s].capStb) rdata[s] <= {DATA_W{viewBit}};
    end
  end

endmodule

// File: rtl/sem_bank.sv
module sem_bank
  import sem_pkg::*;
#(
  parameter int NUM_FLAGS = 8,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter bit TIE_LEFT  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lSel,
  input  logic              lWrEn,
  input  logic              lOe,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic [DATA_W-1:0] lWdata,
  output logic [DATA_W-1:0] lRdata,
  input  logic              rSel,
  input  logic              rWrEn,
  input  logic              rOe,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic [DATA_W-1:0] rWdata,
  output logic [DATA_W-1:0] rRdata
);

  localparam int IDX_W = (NUM_FLAGS > 1) ? $clog2(NUM_FLAGS) : 1;

  portStb_t [SIDES-1:0]         stb;
  logic [SIDES-1:0][IDX_W-1:0]  idx;
  logic [SIDES-1:0][DATA_W-1:0] rdata;
  logic [NUM_FLAGS-1:0]         reqL, reqR, ownL, ownR;

  sem_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_ctrl (
    .clk  (clk),
    .rst  (rst),
    .sel  ({rSel, lSel}),
    .wrEn ({rWrEn, lWrEn}),
    .oe   ({rOe, lOe}),
    .addr ({rAddr, lAddr}),
    .wdata({rWdata, lWdata}),
    .stb  (stb),
    .idx  (idx)
  );

  sem_datapath #(
    .NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W), .IDX_W(IDX_W), .TIE_LEFT(TIE_LEFT)
  ) u_dp (
    .clk  (clk),
    .rst  (rst),
    .stb  (stb),
    .idx  (idx),
    .rdata(rdata),
    .reqL (reqL),
    .reqR (reqR),
    .ownL (ownL),
    .ownR (ownR)
  );

  assign lRdata = rdata[0];
  assign rRdata = rdata[1];

endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
  parameter int NUM_FLAGS = 8,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int IDX_W     = 3,
  parameter bit TIE_LEFT  = 1'b1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 lSel,
  input logic                 lWrEn,
  input logic                 lOe,
  input logic [ADDR_W-1:0]    lAddr,
  input logic [DATA_W-1:0]    lWdata,
  input logic [DATA_W-1:0]    lRdata,
  input logic                 rSel,
  input logic                 rWrEn,
  input logic [ADDR_W-1:0]    rAddr,
  input logic [DATA_W-1:0]    rWdata,
  input logic [NUM_FLAGS-1:0] reqL,
  input logic [NUM_FLAGS-1:0] reqR,
  input logic [NUM_FLAGS-1:0] ownL,
  input logic [NUM_FLAGS-1:0] ownR
);

  logic lAct, lActPrev;
  assign lAct = lSel && lOe && !lWrEn;
  always_ff @(posedge clk) begin
    if (rst) lActPrev <= 1'b0;
    else     lActPrev <= lAct;
  end

  // R7: a continuing read keeps its value
  p_read_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (lAct && lActPrev) |=> $stable(lRdata));

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_chk
    logic lHit, rHit;
    assign lHit = lSel && lWrEn && (lAddr[IDX_W-1:0] == IDX_W'(i));
    assign rHit = rSel && rWrEn && (rAddr[IDX_W-1:0] == IDX_W'(i));

    // R3: the holder's own request latch is set
    p_owner_req_r3: assert property (@(posedge clk) disable iff (rst)
      (ownL[i] |-> !reqL[i]) and (ownR[i] |-> !reqR[i]));

    // R9: a free flag has no pending requests
    p_free_idle_r9: assert property (@(posedge clk) disable iff (rst)
      (!ownL[i] && !ownR[i]) |-> (reqL[i] && reqR[i]));

    // R5: release with a pending request hands over at once
    p_handoff_r5: assert property (@(posedge clk) disable iff (rst)
      (ownL[i] && lHit && lWdata[0] && !reqR[i] && !(rHit && rWdata[0]))
        |=> ownR[i]);

    // R8: same-cycle request tie follows the parameter
    p_tie_r8: assert property (@(posedge clk) disable iff (rst)
      (!ownL[i] && !ownR[i] && lHit && !lWdata[0] && rHit && !rWdata[0])
        |=> (TIE_LEFT ? ownL[i] : ownR[i]));
  end

endmodule

bind sem_bank sem_bank_chk #(
  .NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .IDX_W(IDX_W), .TIE_LEFT(TIE_LEFT)
) u_chk (
  .clk(clk), .rst(rst),
  .lSel(lSel), .lWrEn(lWrEn), .lOe(lOe), .lAddr(lAddr), .lWdata(lWdata),
  .lRdata(lRdata),
  .rSel(rSel), .rWrEn(rWrEn), .rAddr(rAddr), .rWdata(rWdata),
  .reqL(reqL), .reqR(reqR), .ownL(ownL), .ownR(ownR)
);

// File: tb/sem_bank_test.sv
module sem_bank_test;

  localparam int NF = 8;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam bit TIE_L = 1'b1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          lSel = 0, lWrEn = 0, lOe = 0, rSel = 0, rWrEn = 0, rOe = 0;
  logic [AW-1:0] lAddr = '0, rAddr = '0;
  logic [DW-1:0] lWdata = '0, rWdata = '0;
  logic [DW-1:0] lRdata, rRdata;

  int checks = 0;
  int errors = 0;

  // model: 0 free, 1 left holds, 2 right holds
  int mOwn[NF];
  bit mReq[2][NF];

  always #4 clk = ~clk;

  sem_bank #(.NUM_FLAGS(NF), .ADDR_W(AW), .DATA_W(DW), .TIE_LEFT(TIE_L)) uut (
    .clk(clk), .rst(rst),
    .lSel(lSel), .lWrEn(lWrEn), .lOe(lOe), .lAddr(lAddr), .lWdata(lWdata),
    .lRdata(lRdata),
    .rSel(rSel), .rWrEn(rWrEn), .rOe(rOe), .rAddr(rAddr), .rWdata(rWdata),
    .rRdata(rRdata)
  );

  function automatic logic [DW-1:0] expView(int side, int f);
    return (mOwn[f] == side + 1) ? {DW{1'b0}} : {DW{1'b1}};
  endfunction

  function automatic void modelWrite(bit lw, int li, bit lb, bit rw, int ri, bit rb);
    for (int f = 0; f < NF; f++) begin
      bit nL = mReq[0][f];
      bit nR = mReq[1][f];
      if (lw && li == f) nL = lb;
      if (rw && ri == f) nR = rb;
      case (mOwn[f])
        0: if (!nL && !nR) mOwn[f] = TIE_L ? 1 : 2;
           else if (!nL) mOwn[f] = 1;
           else if (!nR) mOwn[f] = 2;
        1: if (nL) mOwn[f] = nR ? 0 : 2;
        default: if (nR) mOwn[f] = nL ? 0 : 1;
      endcase
      mReq[0][f] = nL;
      mReq[1][f] = nR;
    end
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mkAddr(int f);
    logic [AW-1:0] a = AW'($urandom);
    a[2:0] = 3'(f);
    return a;
  endfunction

  // one write cycle on either or both sides; called at a negedge
  task automatic wr(bit lw, int li, bit lb, bit rw, int ri, bit rb);
    lSel = lw; lWrEn = lw; lAddr = mkAddr(li);
    lWdata = {DW'($urandom)} & ~DW'(1) | DW'(lb);
    rSel = rw; rWrEn = rw; rAddr = mkAddr(ri);
    rWdata = {DW'($urandom)} & ~DW'(1) | DW'(rb);
    @(posedge clk);
    @(negedge clk);
    lSel = 0; lWrEn = 0; rSel = 0; rWrEn = 0;
    modelWrite(lw, li, lb, rw, ri, rb);
  endtask

  // both sides read flag f, check, then idle one cycle
  task automatic rdBoth(int f, string req);
    lSel = 1; lOe = 1; lWrEn = 0; lAddr = mkAddr(f);
    rSel = 1; rOe = 1; rWrEn = 0; rAddr = mkAddr(f);
    @(posedge clk);
    @(negedge clk);
    check(req, lRdata, expView(0, f));
    check(req, rRdata, expView(1, f));
    lSel = 0; lOe = 0; rSel = 0; rOe = 0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rdAll(string req);
    for (int f = 0; f < NF; f++) rdBoth(f, req);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int f = 0; f < NF; f++) begin
      mOwn[f] = 0; mReq[0][f] = 1; mReq[1][f] = 1;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;

    // R9: reset state
    check("R9 rdata", lRdata, {DW{1'b1}});
    check("R9 rdata", rRdata, {DW{1'b1}});
    rdAll("R9");

    // R3 / R2 / R1: request flag 1 with random upper data and address bits
    wr(1, 1, 0, 0, 0, 1);
    rdBoth(1, "R3 R2 R1");
    rdBoth(0, "R1 neighbour");

    // R4: right requests a held flag, then withdraws; left releases -> free
    wr(0, 0, 1, 1, 1, 0);
    rdBoth(1, "R4 pending");
    wr(0, 0, 1, 1, 1, 1);
    wr(1, 1, 1, 0, 0, 1);
    rdBoth(1, "R4 R5 free");

    // R5: handoff
    wr(1, 3, 0, 0, 0, 1);
    wr(0, 0, 1, 1, 3, 0);
    wr(1, 3, 1, 0, 0, 1);
    rdBoth(3, "R5 handoff");

    // R7: left starts read while waiting; right releases during the read
    wr(0, 0, 1, 1, 2, 0);
    wr(1, 2, 0, 0, 0, 1);
    lSel = 1; lOe = 1; lWrEn = 0; lAddr = mkAddr(2);
    @(posedge clk); @(negedge clk);
    check("R6 read start", lRdata, {DW{1'b1}});
    rSel = 1; rWrEn = 1; rAddr = mkAddr(2); rWdata = 8'h01;
    @(posedge clk); @(negedge clk);
    rSel = 0; rWrEn = 0;
    modelWrite(0, 0, 1, 1, 2, 1);
    @(posedge clk); @(negedge clk);
    check("R7 hold", lRdata, {DW{1'b1}});
    lSel = 0; lOe = 0;
    @(posedge clk); @(negedge clk);
    check("R7 hold after end", lRdata, {DW{1'b1}});
    rdBoth(2, "R7 R5 new read");

    // R8: tie, then loser inherits on release
    wr(1, 6, 0, 1, 6, 0);
    rdBoth(6, "R8 tie");
    wr(TIE_L, 6, 1, !TIE_L, 6, 1);
    rdBoth(6, "R8 loser pending");

    // R10: write strobe without select
    lWrEn = 1; lAddr = mkAddr(0); lWdata = '0;
    rWrEn = 1; rAddr = mkAddr(0); rWdata = '0;
    @(posedge clk); @(negedge clk);
    lWrEn = 0; rWrEn = 0;
    rdBoth(0, "R10");

    // random traffic with frequent collisions
    for (int it = 0; it < 600; it++) begin
      bit lw = ($urandom % 3) != 0;
      bit rw = ($urandom % 3) != 0;
      int li = $urandom % NF;
      int ri = ($urandom % 2) ? li : int'($urandom % NF);
      wr(lw, li, 1'($urandom), rw, ri, 1'($urandom));
      if (it % 4 == 3) rdBoth(li, "R3 R4 R5 R8 random");
      if (it % 100 == 99) rdAll("R6 sweep");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule